// File: doc/BRIEF.md
# SDLC Transmit Framer with Modem Control

This block turns a byte stream into a serial bit-oriented frame on a single transmit data line. Bytes arrive through a valid/ready handshake with an end-of-frame marker. The framer wraps them in opening and closing flags, applies zero-bit insertion for transparency, and appends a 16-bit frame check sequence. The line is paced by an external 1x transmit clock. That clock is never faster than the system clock, so the block samples it in the system clock domain and shifts one line bit on each detected falling edge. Between frames the line rests at one.

In half duplex mode the block drives a request-to-send output. It raises that output while a byte is waiting or a frame is in flight, and it keeps the output high until the closing flag has left. A high clear-to-send input freezes the frame and forces ones onto the line until the input drops. In full duplex mode both modem pins act as plain register bits: the request pin copies a control bit, and the clear-to-send pin is only mirrored back as a status bit. A synchronous reset returns the block to idle and raises a stopped flag. That flag clears when the first frame begins.

Top module: `sdlc_tx_framer`

## Requirements
- R1: While and right after reset, tx_data is 1, rts_out is 0, stopped is 1 and in_ready is 0.
- R2: tx_data changes only in the first few system clock cycles after a falling edge of txclk_in: at most SYNC_STAGES+2 cycles after the edge is first visible, and never during the rest of the bit period.
- R3: Between frames the line carries ones, and no byte is taken.
- R4: A frame is sent as the flag 0x7E (least significant bit first), then the payload bytes in arrival order (each least significant bit first), then the FCS, then the flag 0x7E.
- R5: After five consecutive ones in the payload or FCS, a 0 is inserted. This includes the case just before the closing flag. Flags are never stuffed, and a stuffed zero resets the run.
- R6: The FCS is CRC-16-CCITT in reflected form (polynomial 0x8408 applied to a right-shifting register), preset to 0xFFFF, run over the payload bits. It is sent complemented, bit 0 first.
- R7: A byte with in_last=1 is the last one in its frame. If no byte is valid at a byte boundary, the frame closes after the bytes already taken.
- R8: In half duplex mode (half_duplex=1), rts_out rises one cycle after in_valid is seen while idle. It stays high until the closing flag has been launched, and it is low in idle with no byte pending.
- R9: In half duplex mode, while cts_in=1 every launched bit is a 1. The frame neither starts nor advances and no byte is taken. When cts_in returns to 0, the frame resumes with no bit lost.
- R10: In full duplex mode (half_duplex=0), rts_out equals gp_rts_val one cycle later, and cts_in does not affect the line. In both modes gp_cts_q equals cts_in one cycle later.
- R11: stopped is cleared when the first frame after reset begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_duplex | input | 1 | 1 selects the RTS/CTS handshake, 0 selects register-bit pins |
| in_data | input | BYTE_W | Payload byte |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | This byte ends the frame |
| in_ready | output | 1 | Byte is taken on this clock when in_valid is high |
| txclk_in | input | 1 | External 1x transmit clock, sampled |
| tx_data | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send pin (high means hold) |
| gp_rts_val | input | 1 | Register value for the RTS pin in full duplex |
| rts_out | output | 1 | Request-to-send pin |
| gp_cts_q | output | 1 | Registered copy of the CTS pin |
| stopped | output | 1 | Set by reset, cleared when a frame begins |

## Verification
Most internal faults in this block appear on the serial line within one bit period. A wrong bit counter or state shifts the flag out of place. A missed stuffing decision shows up as a sixth consecutive one. A corrupted CRC register changes the FCS bits before the closing flag. So the recovered stream, compared bit by bit against a model frame, exposes each fault within the frame that carries it. Modem-side faults show up on rts_out and in_ready within one or two system clocks of a change on in_valid, cts_in or gp_rts_val. A line that fails to hold during a clear-to-send stall shows up as a zero in a hold period.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BODY,
    ST_FCS,
    ST_CLOSE
  } tx_state_e;
endpackage

// File: rtl/sdlc_edge_sync.sv
module sdlc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall_tick
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  // old sample high, newer sample low: a falling edge has crossed
  assign fall_tick = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/sdlc_crc_unit.sv
module sdlc_crc_unit #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic step,
  input  logic din,
  input  logic shift,
  output logic fcs_bit
);
  logic [W-1:0] crc;

  always_ff @(posedge clk) begin
    if (rst || init) crc <= INIT;
    else if (step)   crc <= (crc >> 1) ^ ((crc[0] ^ din) ? POLY : '0);
    else if (shift)  crc <= {1'b1, crc[W-1:1]};
  end

  assign fcs_bit = ~crc[0];
endmodule

// File: rtl/sdlc_modem_ctl.sv
module sdlc_modem_ctl (
  input  logic clk,
  input  logic rst,
  input  logic half_duplex,
  input  logic cts_in,
  input  logic gp_rts_val,
  input  logic in_valid,
  input  logic busy,
  output logic rts_out,
  output logic gp_cts_q,
  output logic hold
);
  assign hold = half_duplex & cts_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_out  <= 1'b0;
      gp_cts_q <= 1'b0;
    end else begin
      rts_out  <= half_duplex ? (in_valid | busy) : gp_rts_val;
      gp_cts_q <= cts_in;
    end
  end
endmodule

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer
  import sdlc_tx_pkg::*;
#(
  parameter int               BYTE_W      = 8,
  parameter int               CRC_W       = 16,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
  parameter logic [BYTE_W-1:0] FLAG       = 8'h7E,
  parameter int               STUFF_RUN   = 5,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_duplex,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              txclk_in,
  output logic              tx_data,
  input  logic              cts_in,
  input  logic              gp_rts_val,
  output logic              rts_out,
  output logic              gp_cts_q,
  output logic              stopped
);
  localparam int CNT_W = $clog2(CRC_W);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_FCS  = CNT_W'(CRC_W - 1);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(STUFF_RUN);

  tx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [RUN_W-1:0]  ones;
  logic [BYTE_W-1:0] cur;
  logic              cur_last;
  logic              edge_tick, hold, adv, stuff_now, fcs_bit, need_fetch, take;
  logic [IDX_W-1:0]  idx;

  sdlc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(txclk_in), .fall_tick(edge_tick)
  );

  sdlc_modem_ctl u_modem (
    .clk(clk), .rst(rst), .half_duplex(half_duplex), .cts_in(cts_in),
    .gp_rts_val(gp_rts_val), .in_valid(in_valid), .busy(st != ST_IDLE),
    .rts_out(rts_out), .gp_cts_q(gp_cts_q), .hold(hold)
  );

  assign idx       = cnt[IDX_W-1:0];
  assign adv       = edge_tick & ~hold;
  assign stuff_now = (ones == RUN_LIMIT);
  assign need_fetch = (st == ST_OPEN && cnt == LAST_BIT) ||
                      (st == ST_BODY && !stuff_now && cnt == LAST_BIT && !cur_last);
  assign in_ready  = adv & need_fetch;
  assign take      = in_ready & in_valid;

  sdlc_crc_unit #(.W(CRC_W), .POLY(CRC_POLY), .INIT('1)) u_crc (
    .clk(clk), .rst(rst),
    .init(adv && st == ST_IDLE && in_valid),
    .step(adv && st == ST_BODY && !stuff_now),
    .din(cur[idx]),
    .shift(adv && st == ST_FCS && !stuff_now),
    .fcs_bit(fcs_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ones     <= '0;
      cur      <= '0;
      cur_last <= 1'b0;
      tx_data  <= 1'b1;
      stopped  <= 1'b1;
    end else if (edge_tick) begin
      if (hold) begin
        tx_data <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: begin
            tx_data <= 1'b1;
            if (in_valid) begin
              tx_data <= FLAG[0];
              st      <= ST_OPEN;
              cnt     <= CNT_W'(1);
              ones    <= '0;
              stopped <= 1'b0;
            end
          end
          ST_OPEN: begin
            tx_data <= FLAG[idx];
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (take) begin
                cur      <= in_data;
                cur_last <= in_last;
                st       <= ST_BODY;
              end else begin
                st <= ST_FCS;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_BODY: begin
            if (stuff_now) begin
              tx_data <= 1'b0;
              ones    <= '0;
            end else begin
              tx_data <= cur[idx];
              ones    <= cur[idx] ? ones + 1'b1 : '0;
              if (cnt == LAST_BIT) begin
                cnt <= '0;
                if (take) begin
                  cur      <= in_data;
                  cur_last <= in_last;
                end else begin
                  st <= ST_FCS;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_FCS: begin
            if (stuff_now) begin
              tx_data <= 1'b0;
              ones    <= '0;
            end else begin
              tx_data <= fcs_bit;
              ones    <= fcs_bit ? ones + 1'b1 : '0;
              if (cnt == LAST_FCS) begin
                cnt <= '0;
                st  <= ST_CLOSE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_CLOSE: begin
            ones <= '0;
            if (cnt == '0 && stuff_now) begin
              tx_data <= 1'b0;
            end else begin
              tx_data <= FLAG[idx];
              if (cnt == LAST_BIT) begin
                cnt <= '0;
                st  <= ST_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdlc_tx_framer_chk.sv
module sdlc_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic edge_tick,
  input logic tx_data,
  input logic rts_out,
  input logic half_duplex,
  input logic gp_rts_val,
  input logic cts_in,
  input logic stopped,
  input logic in_ready
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (tx_data && !rts_out && stopped && !in_ready));

  assert_line_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !edge_tick |=> $stable(tx_data));

  assert_hold_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (half_duplex && cts_in && edge_tick) |=> tx_data);

  assert_no_take_in_hold_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (edge_tick && !(half_duplex && cts_in)));

  assert_gp_rts_R10: assert property (@(posedge clk) disable iff (rst)
    !half_duplex |=> (rts_out == $past(gp_rts_val)));
endmodule

bind sdlc_tx_framer sdlc_tx_framer_chk u_chk (
  .clk(clk), .rst(rst), .edge_tick(edge_tick), .tx_data(tx_data),
  .rts_out(rts_out), .half_duplex(half_duplex), .gp_rts_val(gp_rts_val),
  .cts_in(cts_in), .stopped(stopped), .in_ready(in_ready)
);

// File: tb/tb_sdlc_tx_framer.sv
module tb_sdlc_tx_framer;
  logic       clk = 1'b0, rst = 1'b1, half_duplex = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic       txclk_in = 1'b1, tx_data, cts_in = 1'b0, gp_rts_val = 1'b0;
  logic       rts_out, gp_cts_q, stopped;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] payload[$];
  bit exp_q[$];
  bit rx_q[$];
  bit collecting = 0;
  bit saw_ready = 0;

  sdlc_tx_framer dut (
    .clk(clk), .rst(rst), .half_duplex(half_duplex), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .txclk_in(txclk_in), .tx_data(tx_data), .cts_in(cts_in),
    .gp_rts_val(gp_rts_val), .rts_out(rts_out), .gp_cts_q(gp_cts_q),
    .stopped(stopped)
  );

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #60 txclk_in = ~txclk_in;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R2: line changes only just after a falling txclk edge
  logic prev_tx = 1'b1, prev_tclk = 1'b1;
  int   fall_age = 100;
  always @(negedge clk) begin
    if (prev_tclk && !txclk_in) fall_age = 0;
    else fall_age++;
    if (!rst && tx_data !== prev_tx)
      chk(fall_age <= 4, "R2", "line change distance from txclk fall", fall_age, 4);
    prev_tx   = tx_data;
    prev_tclk = txclk_in;
    if (in_ready) saw_ready = 1;
  end

  // receiver-side sampling on the rising transmit clock edge
  always @(posedge txclk_in) begin
    if (collecting) begin
      if (half_duplex && cts_in) chk(tx_data === 1'b1, "R9", "hold bit", tx_data, 1);
      else rx_q.push_back(tx_data);
    end
  end

  // reference frame from the requirements (R4 R5 R6)
  function automatic void build_expected();
    logic [15:0] c = 16'hFFFF;
    bit body[$];
    int run = 0;
    exp_q.delete();
    foreach (payload[i])
      for (int b = 0; b < 8; b++) begin
        bit v = payload[i][b];
        body.push_back(v);
        if ((c[0] ^ v) != 1'b0) c = (c >> 1) ^ 16'h8408;
        else c = c >> 1;
      end
    c = ~c;
    for (int b = 0; b < 16; b++) body.push_back(c[b]);
    for (int b = 0; b < 8; b++) exp_q.push_back(8'h7E >> b);
    foreach (body[i]) begin
      exp_q.push_back(body[i]);
      if (body[i]) run++; else run = 0;
      if (run == 5) begin exp_q.push_back(1'b0); run = 0; end
    end
    for (int b = 0; b < 8; b++) exp_q.push_back(8'h7E >> b);
  endfunction

  task automatic feed(input bit use_last);
    for (int i = 0; i < payload.size(); i++) begin
      in_data  = payload[i];
      in_last  = use_last && (i == payload.size() - 1);
      in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic analyze(input string req);
    int  i = 0;
    bit  tail_ok = 1;
    while (i < rx_q.size() && rx_q[i] == 1'b1) i++;
    chk(i < rx_q.size(), "R4", "opening flag found", i, 0);
    foreach (exp_q[j]) begin
      if (i + j < rx_q.size())
        chk(rx_q[i + j] == exp_q[j], req, $sformatf("frame bit %0d", j),
            rx_q[i + j], exp_q[j]);
      else
        chk(0, req, $sformatf("frame bit %0d missing", j), 0, exp_q[j]);
    end
    for (int k = i + exp_q.size(); k < rx_q.size(); k++)
      if (rx_q[k] != 1'b1) tail_ok = 0;
    chk(tail_ok, "R3", "idle ones after frame", tail_ok, 1);
  endtask

  task automatic run_frame(input string req, input bit use_last);
    rx_q.delete();
    build_expected();
    collecting = 1;
    feed(use_last);
    repeat (60) @(posedge txclk_in);
    collecting = 0;
    #1;
    analyze(req);
  endtask

  initial begin
    #1000000;
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(tx_data === 1'b1, "R1", "tx_data in reset", tx_data, 1);
    chk(rts_out === 1'b0, "R1", "rts_out in reset", rts_out, 0);
    chk(stopped === 1'b1, "R1", "stopped in reset", stopped, 1);
    chk(in_ready === 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst = 1'b0;

    // R10 register-bit pins in full duplex
    gp_rts_val = 1'b1; cts_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(rts_out === 1'b1, "R10", "rts follows register bit", rts_out, 1);
    chk(gp_cts_q === 1'b1, "R10", "cts mirrored", gp_cts_q, 1);
    gp_rts_val = 1'b0;
    repeat (40) @(negedge clk);
    chk(rts_out === 1'b0, "R10", "rts follows register bit low", rts_out, 0);
    chk(saw_ready == 0, "R3", "no byte taken in idle", saw_ready, 0);

    // R4 R6 basic frame; cts high is ignored in full duplex (R10)
    payload = '{8'h01, 8'h03, 8'hA5};
    run_frame("R4", 1);
    chk(stopped === 1'b0, "R11", "stopped cleared after frame start", stopped, 0);
    cts_in = 1'b0;

    // R5 long runs of ones
    payload = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
    run_frame("R5", 1);
    payload = '{8'h1F, 8'hC4, 8'h6B, 8'hEF};
    run_frame("R6", 1);

    // R8 half duplex request-to-send
    half_duplex = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(rts_out === 1'b0, "R8", "rts idle in half duplex", rts_out, 0);
    payload = '{8'hC3, 8'h5A};
    rx_q.delete(); build_expected(); collecting = 1;
    fork
      feed(1);
      begin
        @(posedge clk); @(negedge clk); @(negedge clk);
        chk(rts_out === 1'b1, "R8", "rts raised on pending byte", rts_out, 1);
        repeat (30) @(posedge txclk_in);
        chk(rts_out === 1'b1, "R8", "rts held mid frame", rts_out, 1);
      end
    join
    repeat (60) @(posedge txclk_in);
    collecting = 0; #1;
    analyze("R8");
    chk(rts_out === 1'b0, "R8", "rts dropped after frame", rts_out, 0);

    // R9 clear-to-send hold before and during a frame
    @(posedge txclk_in); #1 cts_in = 1'b1;
    payload = '{8'h96, 8'h11, 8'hE7};
    rx_q.delete(); build_expected(); collecting = 1; saw_ready = 0;
    fork
      feed(1);
      begin
        repeat (10) @(posedge txclk_in);
        chk(saw_ready == 0, "R9", "no byte taken while held", saw_ready, 0);
        chk(rts_out === 1'b1, "R9", "rts up while waiting", rts_out, 1);
        #1 cts_in = 1'b0;
        repeat (15) @(posedge txclk_in);
        #1 cts_in = 1'b1;
        repeat (6) @(posedge txclk_in);
        #1 cts_in = 1'b0;
      end
    join
    repeat (60) @(posedge txclk_in);
    collecting = 0; #1;
    analyze("R9");

    // R7 underrun closes frame, and a single last byte
    half_duplex = 1'b0;
    payload = '{8'hAB, 8'hCD};
    run_frame("R7", 0);
    payload = '{8'h00};
    run_frame("R7", 1);

    // R1 R11 reset raises stopped again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(stopped === 1'b1, "R11", "stopped after second reset", stopped, 1);
    chk(tx_data === 1'b1, "R1", "line high after reset", tx_data, 1);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule